// File: doc/BRIEF.md
# Paired Base-Register Operand Address Former

This block turns a 36-bit instruction word into an operand address. A single format flag in the instruction chooses between two layouts. The flat layout carries an 18-bit address directly. The based layout carries a 3-bit base-register number and a 15-bit displacement. The block holds a file of eight 24-bit base registers. Each register has an 18-bit address field and a 6-bit control field. A control flag marks a register as external or internal. An external register holds a segment number. An internal register holds an offset and names an external partner, which supplies the segment.

A mode input selects absolute or appending addressing. In absolute mode every request returns the flat 18-bit field with no segment. In appending mode a based request yields a segment number and an 18-bit offset. If the pairing is malformed, it raises a fault instead. Results are registered and are marked by a one-cycle valid pulse one clock after the request strobe. Base registers are loaded through a synchronous write port.

Top module: `addr_former`

## Requirements
- R1: Synchronous active-high reset clears rsp_valid, rsp_fault, rsp_seg and rsp_off to zero. It also clears all eight base registers to zero, so they are external with address 0.
- R2: A request strobe on req_valid produces rsp_valid high on the following clock only. A cycle without a strobe gives rsp_valid low on the next clock.
- R3: Instruction layout, with bit 35 as the most significant: [35:33] base number, [32:18] displacement, [17:9] opcode, [8] opcode extension, [7] inhibit, [6] format flag, [5:0] tag. In appending mode (abs_mode=0) with format flag 0, the response is seg=0, off=req_instr[35:18], fault=0.
- R4: In absolute mode (abs_mode=1) every request responds with seg=0, off=req_instr[35:18] and fault=0, whatever the format flag is.
- R5: Base register layout: [17:0] address, [23:18] control. Control bit 0 (register bit 18) is 1 for internal and 0 for external. When the selected register is external in a based request, seg is its address and off is the zero-extended displacement.
- R6: Control bits 3:1 (register bits 21:19) name the partner of an internal register. When the selected register is internal and its partner is external, seg is the partner's address. In that case off is (internal address + displacement) mod 2^18.
- R7: When a selected internal register names a partner that is internal (including itself), the response has fault=1 and seg=off=0.
- R8: A base-register write in the same cycle as a request is resolved with the register contents from before that write. The write is visible to the next request.
- R9: Control bits 5:4 (register bits 23:22) and the opcode, extension, inhibit and tag fields have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Base-register write enable |
| wr_idx | input | 3 | Base register to write |
| wr_data | input | 24 | Value written: control in [23:18], address in [17:0] |
| req_valid | input | 1 | Request strobe |
| req_instr | input | 36 | Instruction word |
| abs_mode | input | 1 | 1 = absolute addressing, 0 = appending |
| rsp_valid | output | 1 | One-cycle pulse marking a response |
| rsp_seg | output | 18 | Segment number |
| rsp_off | output | 18 | Offset, or absolute address in flat cases |
| rsp_fault | output | 1 | Pairing fault |

## Verification
Every response is due exactly one clock after its strobe. A single register stage sits between the request inputs and the outputs. The bench drives the strobe on a falling edge and samples rsp_valid and the address fields at the next falling edge. It samples again one falling edge later to confirm that the pulse has dropped. A base-register write takes one clock to land. The same-cycle write case drives a write and a request together, then checks that the response reflects the old contents and that the following request reflects the new ones.

// File: rtl/addr_form_pkg.sv
package addr_form_pkg;

    localparam int NUM_BASE = 8;
    localparam int IDX_W    = $clog2(NUM_BASE);
    localparam int ADDR_W   = 18;
    localparam int CTRL_W   = 6;
    localparam int DISP_W   = 15;
    localparam int BREG_W   = ADDR_W + CTRL_W;
    localparam int INSTR_W  = 36;
    localparam int OP_W     = 9;
    localparam int TAG_W    = 6;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [ADDR_W-1:0] addr;
    } base_reg_t;

    typedef struct packed {
        logic [IDX_W-1:0]  br;
        logic [DISP_W-1:0] disp;
        logic [OP_W-1:0]   op;
        logic              op_ext;
        logic              inhibit;
        logic              based;
        logic [TAG_W-1:0]  tag;
    } instr_t;

    typedef struct packed {
        logic              fault;
        logic [ADDR_W-1:0] seg;
        logic [ADDR_W-1:0] off;
    } result_t;

    function automatic logic is_internal(base_reg_t r);
        return r.ctrl[0];
    endfunction

    function automatic logic [IDX_W-1:0] partner_of(base_reg_t r);
        return r.ctrl[IDX_W:1];
    endfunction

endpackage

// File: rtl/base_reg_file.sv
module base_reg_file
    import addr_form_pkg::*;
#(
    parameter int N_REGS = NUM_BASE,
    parameter int W      = BREG_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(N_REGS)-1:0] wr_idx,
    input  logic [W-1:0]              wr_data,
    input  logic [$clog2(N_REGS)-1:0] rd0_idx,
    output logic [W-1:0]              rd0_data,
    input  logic [$clog2(N_REGS)-1:0] rd1_idx,
    output logic [W-1:0]              rd1_data
);
    localparam int IW = $clog2(N_REGS);

    logic [W-1:0] regs [N_REGS];

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && wr_idx == IW'(g))
                regs[g] <= wr_data;
        end
    end

    assign rd0_data = regs[rd0_idx];
    assign rd1_data = regs[rd1_idx];

    // R8: a write lands at the following edge
    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/addr_resolve.sv
module addr_resolve
    import addr_form_pkg::*;
(
    input  instr_t    instr,
    input  logic      abs_mode,
    input  base_reg_t sel_reg,
    input  base_reg_t par_reg,
    output result_t   res
);
    always_comb begin
        res = '0;
        if (abs_mode || !instr.based) begin
            res.off = {instr.br, instr.disp};
        end else if (!is_internal(sel_reg)) begin
            res.seg = sel_reg.addr;
            res.off = ADDR_W'(instr.disp);
        end else if (is_internal(par_reg)) begin
            res.fault = 1'b1;
        end else begin
            res.seg = par_reg.addr;
            res.off = sel_reg.addr + ADDR_W'(instr.disp);
        end
    end

    logic unused_fields;
    assign unused_fields = ^{instr.op, instr.op_ext, instr.inhibit, instr.tag,
                             sel_reg.ctrl[CTRL_W-1:IDX_W+1],
                             par_reg.ctrl[CTRL_W-1:1]};

endmodule

// File: rtl/addr_former.sv
module addr_former
    import addr_form_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [BREG_W-1:0]  wr_data,
    input  logic               req_valid,
    input  logic [INSTR_W-1:0] req_instr,
    input  logic               abs_mode,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_seg,
    output logic [ADDR_W-1:0]  rsp_off,
    output logic               rsp_fault
);
    instr_t     ins;
    base_reg_t  sel_r, par_r;
    logic [IDX_W-1:0] par_idx;
    result_t    next_res, res_q;
    logic       valid_q;

    assign ins     = instr_t'(req_instr);
    assign par_idx = partner_of(sel_r);

    base_reg_t  sel_raw, par_raw;
    assign sel_r = sel_raw;
    assign par_r = par_raw;

    base_reg_file #(.N_REGS(NUM_BASE), .W(BREG_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd0_idx  (ins.br),
        .rd0_data (sel_raw),
        .rd1_idx  (par_idx),
        .rd1_data (par_raw)
    );

    addr_resolve u_resolve (
        .instr    (ins),
        .abs_mode (abs_mode),
        .sel_reg  (sel_r),
        .par_reg  (par_r),
        .res      (next_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid)
                res_q <= next_res;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_seg   = res_q.seg;
    assign rsp_off   = res_q.off;
    assign rsp_fault = res_q.fault;

    p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_abs_flat_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && abs_mode) |=>
            (!rsp_fault && rsp_seg == '0 && rsp_off == $past(req_instr[35:18])));

    p_short_flat_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_instr[6]) |=>
            (!rsp_fault && rsp_seg == '0 && rsp_off == $past(req_instr[35:18])));

    p_fault_zero_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_seg == '0 && rsp_off == '0));

endmodule

// File: tb/test_addr_former.sv
`timescale 1ns/1ps
module test_addr_former;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [23:0] wr_data;
    logic        req_valid;
    logic [35:0] req_instr;
    logic        abs_mode;
    logic        rsp_valid;
    logic [17:0] rsp_seg, rsp_off;
    logic        rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    addr_former i_addr_former (
        .clk, .rst, .wr_en, .wr_idx, .wr_data, .req_valid, .req_instr,
        .abs_mode, .rsp_valid, .rsp_seg, .rsp_off, .rsp_fault
    );

    function automatic logic [35:0] based_ins(logic [2:0] br, logic [14:0] d,
                                              logic [8:0] op, logic [5:0] tag);
        return {br, d, op, 1'b1, 1'b1, 1'b1, tag};
    endfunction

    function automatic logic [35:0] flat_ins(logic [17:0] a, logic [8:0] op,
                                             logic [5:0] tag);
        return {a, op, 1'b0, 1'b1, 1'b0, tag};
    endfunction

    task automatic chk_bit(string rq, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", rq, act, exp);
        end
    endtask

    task automatic chk_rsp(string rq, logic ef, logic [17:0] es, logic [17:0] eo);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_fault !== ef || rsp_seg !== es || rsp_off !== eo) begin
            errors++;
            $display("FAIL %s: got v=%b f=%b seg=%h off=%h expected v=1 f=%b seg=%h off=%h",
                     rq, rsp_valid, rsp_fault, rsp_seg, rsp_off, ef, es, eo);
        end
    endtask

    task automatic write_reg(logic [2:0] idx, logic [5:0] ctrl, logic [17:0] addr);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = {ctrl, addr};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive one request; response is sampled at the next falling edge
    task automatic request(logic [35:0] ins, logic am);
        @(negedge clk);
        req_valid = 1'b1; req_instr = ins; abs_mode = am;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; wr_en = 0; wr_idx = 0; wr_data = 0;
        req_valid = 0; req_instr = 0; abs_mode = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_bit("R1 valid low", rsp_valid, 1'b0);
        chk_bit("R1 fault low", rsp_fault, 1'b0);
        chk_bit("R1 seg zero", rsp_seg == 18'h0, 1'b1);
        chk_bit("R1 off zero", rsp_off == 18'h0, 1'b1);
        request(based_ins(3'd3, 15'h1234, 9'h0, 6'h0), 1'b0);
        chk_rsp("R1 regs cleared", 1'b0, 18'h0, 18'h01234);
    endtask

    task automatic t_pulse;
        request(flat_ins(18'h00042, 9'h1, 6'h2), 1'b0);
        chk_bit("R2 valid after strobe", rsp_valid, 1'b1);
        @(negedge clk);
        chk_bit("R2 single-cycle pulse", rsp_valid, 1'b0);
        @(negedge clk);
        chk_bit("R2 idle stays low", rsp_valid, 1'b0);
    endtask

    task automatic t_flat;
        request(flat_ins(18'h2ABCD, 9'h000, 6'h00), 1'b0);
        chk_rsp("R3 flat pattern A", 1'b0, 18'h0, 18'h2ABCD);
        request(flat_ins(18'h3FFFF, 9'h1FF, 6'h3F), 1'b0);
        chk_rsp("R3 flat pattern B", 1'b0, 18'h0, 18'h3FFFF);
    endtask

    task automatic t_absolute;
        write_reg(3'd2, 6'h00, 18'h15555);
        request(based_ins(3'd2, 15'h0123, 9'h55, 6'h11), 1'b1);
        chk_rsp("R4 absolute ignores based", 1'b0, 18'h0, {3'd2, 15'h0123});
        request(flat_ins(18'h10001, 9'h0, 6'h0), 1'b1);
        chk_rsp("R4 absolute flat", 1'b0, 18'h0, 18'h10001);
    endtask

    task automatic t_external;
        request(based_ins(3'd2, 15'h0123, 9'h0AA, 6'h05), 1'b0);
        chk_rsp("R5 external", 1'b0, 18'h15555, 18'h00123);
    endtask

    task automatic t_internal;
        write_reg(3'd5, 6'h05, 18'h3FFF0);   // internal, partner 2
        request(based_ins(3'd5, 15'h0020, 9'h0, 6'h0), 1'b0);
        chk_rsp("R6 internal wraps", 1'b0, 18'h15555, 18'h00010);
        request(based_ins(3'd5, 15'h0001, 9'h0, 6'h0), 1'b0);
        chk_rsp("R6 internal no wrap", 1'b0, 18'h15555, 18'h3FFF1);
    endtask

    task automatic t_fault;
        write_reg(3'd4, 6'h0B, 18'h00100);   // internal, partner 5 (internal)
        request(based_ins(3'd4, 15'h0007, 9'h0, 6'h0), 1'b0);
        chk_rsp("R7 partner internal", 1'b1, 18'h0, 18'h0);
        write_reg(3'd3, 6'h07, 18'h00200);   // internal, partner itself
        request(based_ins(3'd3, 15'h0007, 9'h0, 6'h0), 1'b0);
        chk_rsp("R7 self partner", 1'b1, 18'h0, 18'h0);
    endtask

    task automatic t_reserved;
        write_reg(3'd6, 6'h30, 18'h00777);   // external, reserved bits set
        request(based_ins(3'd6, 15'h0040, 9'h1FF, 6'h3F), 1'b0);
        chk_rsp("R9 reserved external", 1'b0, 18'h00777, 18'h00040);
        write_reg(3'd7, 6'h3D, 18'h00100);   // internal, partner 6, reserved set
        request(based_ins(3'd7, 15'h7FFF, 9'h0, 6'h0), 1'b0);
        chk_rsp("R9 reserved internal", 1'b0, 18'h00777, 18'h080FF);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd2; wr_data = {6'h00, 18'h00ABC};
        req_valid = 1'b1; req_instr = based_ins(3'd2, 15'h0001, 9'h0, 6'h0);
        abs_mode = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk_rsp("R8 old contents used", 1'b0, 18'h15555, 18'h00001);
        request(based_ins(3'd2, 15'h0001, 9'h0, 6'h0), 1'b0);
        chk_rsp("R8 new contents visible", 1'b0, 18'h00ABC, 18'h00001);
    endtask

    initial begin
        t_reset();
        t_pulse();
        t_flat();
        t_absolute();
        t_external();
        t_internal();
        t_fault();
        t_reserved();
        t_same_cycle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule